// File: doc/BRIEF.md
# CPU Clock Divider with Clock-Stop Standby and Wakeup

This block derives the processor clock from a fast system clock. Software programs the divide ratio through a small register write port. Writing a non-zero value into the stop field of the clock control register gates the processor clock off, and the block enters standby. While it is in standby, the configuration registers hold their contents.

Two kinds of source bring the block back to the running state. The first is the eight key inputs: a key wakes the block when it differs from a snapshot that software captured with a read strobe before standby. The second is six interrupt request lines. Each source has its own enable bit and can wake the block only when that bit is set. Every wakeup puts the divider back to divide-by-8, whatever ratio was programmed before, and reports the event with a one-cycle pulse. If a wakeup condition already holds when the stop write arrives, the clock keeps running and the pulse is raised at once.

The gated clock output is the system clock ANDed with an enable. The enable is updated only on falling system clock edges, so the output never produces a partial pulse.

Top module: `cpuclk_sby_ctrl`

## Requirements
- R1: After reset the processor clock has one rising edge per 8 system clock cycles, and `wake_pulse` is 0.
- R2: A write to address 0 with bits 2:0 equal to zero loads the ratio code from bits 5:3. Codes 0 to 6 select divide by 1, 2, 4, 8, 16, 32 and 64, which gives one `cpu_clk` rising edge per N system cycles. Code 7 selects divide by 8.
- R3: A write to address 0 with bits 2:0 non-zero, made while running and with no wakeup condition true, enters standby. After that write, `cpu_clk` has no rising edge.
- R4: A one-cycle `key_latch_rd` pulse while running captures `key_in` into the snapshot. A key wakeup condition holds when any key bit whose enable is set differs from its snapshot bit. Key enables are address 1, bits 7:0.
- R5: An interrupt wakeup condition holds when `irq_req[i]` is high and its enable, address 1 bit 8+i, is set.
- R6: Key bits and interrupt lines whose enable is clear cause no wakeup. Without a wakeup condition the block stays in standby and `wake_pulse` stays 0.
- R7: A wakeup condition seen in standby returns the block to running at the next system clock edge. That edge forces the ratio to divide-by-8 and raises `wake_pulse` for exactly one cycle.
- R8: A stop write made while a wakeup condition already holds leaves `cpu_clk` running. On the next cycle `wake_pulse` is 1 and the ratio is divide-by-8.
- R9: Register writes made during standby are ignored. The enables and the snapshot keep the values they had on entry.
- R10: The clock enable changes only while the system clock is low, so every `cpu_clk` rising edge coincides with a system clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle |
| reg_wr_addr | input | 2 | Register select: 0 clock control, 1 wakeup enables |
| reg_wr_data | input | 14 | Write data |
| key_in | input | 8 | Key inputs |
| key_latch_rd | input | 1 | Read strobe that captures the key snapshot |
| irq_req | input | 6 | Interrupt request lines |
| cpu_clk | output | 1 | Gated, divided processor clock |
| wake_pulse | output | 1 | One-cycle wakeup indication |

## Verification
The assertions take every input to be synchronous to the system clock: key and interrupt levels, write strobes and the latch strobe are sampled only at rising edges, and no synchronizer is assumed in front of them. The stimulus changes every input just after a falling edge, so inputs are stable at the rising edge that samples them. Write and latch strobes last exactly one cycle. Wakeup sources are changed only when the run or standby state needed by each check has already settled.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int DIV_CODE_W = 3;
  localparam int MAX_SHIFT  = 6;
  localparam int CNT_W      = MAX_SHIFT;
  localparam int ADDR_W     = 2;
  localparam int STOP_W     = 3;
  localparam int STOP_LSB   = 0;
  localparam int RATIO_LSB  = STOP_LSB + STOP_W;

  localparam logic [DIV_CODE_W-1:0] SLOW_CODE = 3'd3;
  localparam logic [ADDR_W-1:0]     ADDR_CLK  = 2'd0;
  localparam logic [ADDR_W-1:0]     ADDR_EN   = 2'd1;

  // Terminal count (N-1) of the divider for a ratio code; out-of-range codes
  // fall back to the slow ratio.
  function automatic logic [CNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
    logic [CNT_W:0]        span;
    logic [DIV_CODE_W-1:0] eff;
    eff  = (int'(code) > MAX_SHIFT) ? SLOW_CODE : code;
    span = (CNT_W+1)'(1) << eff;
    span = span - (CNT_W+1)'(1);
    return span[CNT_W-1:0];
  endfunction

  function automatic logic stop_field_set(input logic [STOP_W-1:0] f);
    return |f;
  endfunction
endpackage

// File: rtl/csw_regs.sv
module csw_regs
  import csw_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter int IRQ_W = 6,
  parameter int WR_W  = KEY_W + IRQ_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WR_W-1:0]       wr_data,
  input  logic                  latch_rd,
  input  logic [KEY_W-1:0]      key_in,
  input  logic                  force_slow,
  output logic [DIV_CODE_W-1:0] ratio_code,
  output logic [KEY_W-1:0]      key_en,
  output logic [IRQ_W-1:0]      irq_en,
  output logic [KEY_W-1:0]      key_snap,
  output logic                  stop_req,
  output logic                  ratio_wr
);
  logic clk_sel;
  logic en_sel;
  logic stop_bits;

  assign clk_sel   = run && wr_en && (wr_addr == ADDR_CLK);
  assign en_sel    = run && wr_en && (wr_addr == ADDR_EN);
  assign stop_bits = stop_field_set(wr_data[STOP_LSB +: STOP_W]);
  assign stop_req  = clk_sel && stop_bits;
  assign ratio_wr  = clk_sel && !stop_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_code <= SLOW_CODE;
      key_en     <= '0;
      irq_en     <= '0;
      key_snap   <= '0;
    end else begin
      if (force_slow)
        ratio_code <= SLOW_CODE;
      else if (ratio_wr)
        ratio_code <= wr_data[RATIO_LSB +: DIV_CODE_W];
      if (en_sel) begin
        key_en <= wr_data[KEY_W-1:0];
        irq_en <= wr_data[KEY_W +: IRQ_W];
      end
      if (run && latch_rd)
        key_snap <= key_in;
    end
  end
endmodule

// File: rtl/csw_wake.sv
module csw_wake #(
  parameter int KEY_W = 8,
  parameter int IRQ_W = 6
) (
  input  logic [KEY_W-1:0] key_in,
  input  logic [KEY_W-1:0] key_snap,
  input  logic [KEY_W-1:0] key_en,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             wake_cond
);
  logic [KEY_W-1:0] key_hit;
  logic [IRQ_W-1:0] irq_hit;

  for (genvar k = 0; k < KEY_W; k++) begin : g_key
    assign key_hit[k] = key_en[k] & (key_in[k] ^ key_snap[k]);
  end

  for (genvar q = 0; q < IRQ_W; q++) begin : g_irq
    assign irq_hit[q] = irq_en[q] & irq_req[q];
  end

  assign wake_cond = (|key_hit) | (|irq_hit);
endmodule

// File: rtl/csw_div.sv
module csw_div
  import csw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  output logic             gate,
  output logic             cpu_clk
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || restart || at_last)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

  // Enable only from registered state, updated while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      gate <= 1'b0;
    else
      gate <= run && at_last;
  end

  assign cpu_clk = clk & gate;
endmodule

// File: rtl/cpuclk_sby_ctrl.sv
module cpuclk_sby_ctrl
  import csw_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter int IRQ_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_wr_addr,
  input  logic [KEY_W+IRQ_W-1:0]   reg_wr_data,
  input  logic [KEY_W-1:0]         key_in,
  input  logic                     key_latch_rd,
  input  logic [IRQ_W-1:0]         irq_req,
  output logic                     cpu_clk,
  output logic                     wake_pulse
);
  localparam int WR_W = KEY_W + IRQ_W;

  logic                  run_q;
  logic                  stop_req;
  logic                  ratio_wr;
  logic                  wake_cond;
  logic                  wake_evt;
  logic                  enter_sby;
  logic                  clk_gate;
  logic [DIV_CODE_W-1:0] ratio_code;
  logic [KEY_W-1:0]      key_en;
  logic [IRQ_W-1:0]      irq_en;
  logic [KEY_W-1:0]      key_snap;
  logic [CNT_W-1:0]      div_end;

  csw_regs #(.KEY_W(KEY_W), .IRQ_W(IRQ_W), .WR_W(WR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .latch_rd   (key_latch_rd),
    .key_in     (key_in),
    .force_slow (wake_evt),
    .ratio_code (ratio_code),
    .key_en     (key_en),
    .irq_en     (irq_en),
    .key_snap   (key_snap),
    .stop_req   (stop_req),
    .ratio_wr   (ratio_wr)
  );

  csw_wake #(.KEY_W(KEY_W), .IRQ_W(IRQ_W)) u_wake (
    .key_in    (key_in),
    .key_snap  (key_snap),
    .key_en    (key_en),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .wake_cond (wake_cond)
  );

  // A stop write races a pending wakeup: the wakeup wins.
  assign enter_sby = stop_req && !wake_cond;
  assign wake_evt  = run_q ? (stop_req && wake_cond) : wake_cond;
  assign div_end   = div_last(ratio_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= wake_evt;
      if (enter_sby)
        run_q <= 1'b0;
      else if (wake_evt)
        run_q <= 1'b1;
    end
  end

  csw_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (ratio_wr || wake_evt),
    .last    (div_end),
    .gate    (clk_gate),
    .cpu_clk (cpu_clk)
  );
endmodule

// File: rtl/csw_chk.sv
module csw_chk
  import csw_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter int IRQ_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic                  stop_req,
  input logic                  wake_cond,
  input logic                  wake_pulse,
  input logic [DIV_CODE_W-1:0] ratio_code,
  input logic [KEY_W-1:0]      key_en,
  input logic [IRQ_W-1:0]      irq_en,
  input logic [KEY_W-1:0]      key_snap,
  input logic                  gate
);
  assert_stop_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stop_req && !wake_cond) |=> !run);

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !gate);

  assert_standby_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wake_cond) |=> (run && wake_pulse));

  assert_wake_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (ratio_code == SLOW_CODE));

  assert_pending_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stop_req && wake_cond) |=> (run && wake_pulse));

  assert_no_stray_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wake_cond) |=> (!run && !wake_pulse));

  assert_state_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(key_en) && $stable(irq_en) && $stable(key_snap)));

  always @(gate) begin
    if (rst_n) begin
      assert_gate_clk_low_R10: assert (clk == 1'b0);
    end
  end
endmodule

bind cpuclk_sby_ctrl csw_chk #(.KEY_W(KEY_W), .IRQ_W(IRQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_q),
  .stop_req   (stop_req),
  .wake_cond  (wake_cond),
  .wake_pulse (wake_pulse),
  .ratio_code (ratio_code),
  .key_en     (key_en),
  .irq_en     (irq_en),
  .key_snap   (key_snap),
  .gate       (clk_gate)
);

// File: tb/tb_cpuclk_sby_ctrl.sv
`timescale 1ns/1ps
module tb_cpuclk_sby_ctrl;
  localparam int KW  = 8;
  localparam int IW  = 6;
  localparam int WIN = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_addr = '0;
  logic [13:0]   reg_wr_data = '0;
  logic [KW-1:0] key_in = '0;
  logic          key_latch_rd = 1'b0;
  logic [IW-1:0] irq_req = '0;
  logic          cpu_clk;
  logic          wake_pulse;

  cpuclk_sby_ctrl #(.KEY_W(KW), .IRQ_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .key_in(key_in), .key_latch_rd(key_latch_rd),
    .irq_req(irq_req), .cpu_clk(cpu_clk), .wake_pulse(wake_pulse)
  );

  always #4 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  int  edge_cnt = 0;
  int  glitches = 0;
  int  wake_seen = 0;
  bit  mon_busy = 0;
  bit  ended = 0;
  int    exp_q[$];
  string tag_q[$];

  always @(posedge cpu_clk) begin
    edge_cnt++;
    if (clk !== 1'b1) glitches++;
  end

  always @(posedge clk) if (rst_n && wake_pulse === 1'b1) wake_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected rising edges in a WIN-cycle window for a ratio code.
  function automatic int exp_edges(input int code);
    int n;
    n = 1;
    if (code == 7) return WIN / 8;
    for (int i = 0; i < code; i++) n = n * 2;
    return WIN / n;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [13:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic latch_keys();
    @(negedge clk);
    key_latch_rd = 1'b1;
    @(negedge clk);
    key_latch_rd = 1'b0;
  endtask

  task automatic expect_edges(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    wait (!mon_busy && exp_q.size() == 0);
  endtask

  // Scoreboard monitor: pops an expected edge count and measures a window.
  initial begin
    int    e;
    string t;
    int    start;
    forever begin
      wait (exp_q.size() != 0);
      mon_busy = 1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      @(negedge clk);
      start = edge_cnt;
      repeat (WIN) @(negedge clk);
      check((edge_cnt - start) == e, t, edge_cnt - start, e);
      mon_busy = 0;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wake_pulse == 1'b0, "R1 wake after reset", int'(wake_pulse), 0);
    expect_edges(16, "R1 reset ratio");

    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 14'(c << 3));
      expect_edges(exp_edges(c), "R2 ratio code");
    end

    // Key wakeup: enable key bit 0 only, snapshot 0x5A, program /2, stop.
    wr(2'd1, 14'h0001);
    key_in = 8'h5A;
    latch_keys();
    wr(2'd0, 14'(1 << 3));
    wr(2'd0, 14'h0001);
    expect_edges(0, "R3 standby clock off");
    check(wake_seen == 0, "R3 no wake on stop", wake_seen, 0);

    // R9: enable write in standby is ignored, so irq 0 cannot wake.
    wr(2'd1, 14'h3FFF);
    irq_req = 6'h01;
    expect_edges(0, "R9 write ignored");
    check(wake_seen == 0, "R9 wake count", wake_seen, 0);
    irq_req = '0;

    // R6: disabled key bit changes.
    key_in = key_in ^ 8'h02;
    repeat (4) @(negedge clk);
    check(wake_seen == 0, "R6 disabled key", wake_seen, 0);
    expect_edges(0, "R6 disabled key clock");

    // R4: enabled key bit differs from snapshot.
    key_in = key_in ^ 8'h01;
    repeat (3) @(negedge clk);
    check(wake_seen == 1, "R4 key wake", wake_seen, 1);
    expect_edges(16, "R7 forced slow after key wake");

    // Interrupt wakeup: irq 3 enabled only.
    latch_keys();
    wr(2'd1, 14'(1 << (KW + 3)));
    wr(2'd0, 14'(6 << 3));
    expect_edges(2, "R2 divide by 64");
    wr(2'd0, 14'h0007);
    expect_edges(0, "R3 standby via irq test");
    irq_req = 6'h04;
    repeat (4) @(negedge clk);
    check(wake_seen == 1, "R6 disabled irq", wake_seen, 1);
    irq_req = 6'h0C;
    repeat (3) @(negedge clk);
    check(wake_seen == 2, "R5 irq wake", wake_seen, 2);
    expect_edges(16, "R7 forced slow after irq wake");

    // R8: stop while irq 3 still pending.
    wr(2'd0, 14'(2 << 3));
    expect_edges(32, "R2 divide by 4");
    wr(2'd0, 14'h0002);
    check(wake_pulse == 1'b1, "R8 immediate wake", int'(wake_pulse), 1);
    expect_edges(16, "R8 clock keeps running slow");
    irq_req = '0;

    // R4: snapshot comparison with all keys enabled.
    wr(2'd1, 14'h00FF);
    key_in = 8'h0F;
    latch_keys();
    key_in = 8'hF0;
    wr(2'd0, 14'h0001);
    check(wake_pulse == 1'b1, "R4 snapshot mismatch pending", int'(wake_pulse), 1);
    key_in = 8'h0F;
    wr(2'd0, 14'h0004);
    expect_edges(0, "R4 keys match snapshot");
    key_in = 8'h8F;
    repeat (3) @(negedge clk);
    check(wake_seen == 5, "R4 key 7 wake", wake_seen, 5);
    expect_edges(16, "R7 slow after key 7 wake");

    check(glitches == 0, "R10 glitch-free gate", glitches, 0);
    finish_run();
  end
endmodule